// File: doc/BRIEF.md
# Bipolar Line Decoder and Receive Formatter

This block sits on the receive side of one line channel, just after the slicer and the clock recovery. Each received bit period arrives as a pair of pulse indications, one for a positive mark and one for a negative mark. In single-rail operation the block decodes the pair stream into one NRZ data bit per period, using either plain alternate-mark-inversion rules or the HDB3 zero-substitution rules. It raises a violation flag beside any bit that breaks the selected code. In dual-rail retimed operation the two rails pass through unchanged. In raw operation there is no retiming: the rails go straight to the outputs with a selectable polarity, and the output clock is the exclusive-OR of the two rails.

Symbols enter through a valid/ready stream and decoded bits leave through a second valid/ready stream. In the retimed modes a symbol is held in a short window so that a later HDB3 violation pulse can still blank the three bits in front of it. A bit therefore leaves the block only once three newer symbols have been accepted. When the output stream is stalled, the input stream is stalled with it, so no symbol is dropped. In raw mode the two streams are wired through with no storage, and back-pressure passes straight from output to input. The single control pin `edge_hi` has two uses. In the retimed modes it picks which edge of `rclk_o` marks valid data. In raw mode it picks the polarity of the rail outputs.

Top module: `rx_line_fmt`

## Requirements
- R1: While reset is held and directly after it, in a retimed mode (`mode` 00 or 01), `out_valid` is 0, `in_ready` is 1 and `rclk_o` equals `edge_hi`.
- R2: In single-rail mode (`mode`=00) with `hdb3_en`=0, a symbol with exactly one rail high is a mark and decodes to `out_rda`=1. Rails 00 and 11 are spaces and decode to 0. Symbol k appears on the output stream once symbol k+3 has been accepted, and symbols leave in arrival order.
- R3: In single-rail AMI decoding, a mark whose polarity (`in_pos`=1 means positive) equals that of the previous mark sets `out_rdb`=1 for that bit only. The first mark after reset is never flagged, and the flag is never set on a space.
- R4: In single-rail mode with `hdb3_en`=1, a mark of the same polarity as the previous mark, preceded by two spaces, is a substitution. It and the three symbols before it are output as 0, with `out_rdb`=0.
- R5: In single-rail HDB3 decoding, a same-polarity mark that is not preceded by two spaces is output as `out_rda`=1 with `out_rdb`=1.
- R6: In dual-rail retimed mode (`mode`=01), `out_rda` carries `in_pos` and `out_rdb` carries `in_neg` unchanged, with the same three-symbol delay as R2.
- R7: In raw mode (`mode`=1x), `out_rda`/`out_rdb` equal `in_pos`/`in_neg` in the same cycle when `edge_hi`=1 and are their inverses when `edge_hi`=0. `out_valid` follows `in_valid` and `in_ready` follows `out_ready`.
- R8: In raw mode `rclk_o` equals `in_pos` XOR `in_neg` in the same cycle.
- R9: In the retimed modes with `edge_hi`=0, `rclk_o` is high exactly in the cycles in which an output transfer takes place, so data is valid at its rising edge. With `edge_hi`=1 it is the inverse, so data is valid at its falling edge.
- R10: In the retimed modes, while `out_valid`=1 and `out_ready`=0, the output data stays stable, `in_ready` is 0, and every symbol is delivered in order once `out_ready` returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock; one symbol at most per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00 single-rail decode, 01 dual-rail retimed, 1x raw slice |
| hdb3_en | input | 1 | Single-rail code: 1 HDB3, 0 AMI |
| edge_hi | input | 1 | Retimed: clock edge select; raw: rail polarity |
| in_valid | input | 1 | Input symbol present |
| in_ready | output | 1 | Block accepts the input symbol |
| in_pos | input | 1 | Positive pulse indication |
| in_neg | input | 1 | Negative pulse indication |
| out_valid | output | 1 | Output bit present |
| out_ready | input | 1 | Downstream accepts the output bit |
| out_rda | output | 1 | NRZ data / positive rail |
| out_rdb | output | 1 | Violation flag / negative rail |
| rclk_o | output | 1 | Formatted output clock |

## Verification
The bench builds the block with the default window depth of four. With that depth, the oldest symbol blanked by an HDB3 substitution is exactly the one about to leave the window. A clearing error at that boundary therefore shows up on the very next output bit. The same depth puts the first output transfer after the fourth accepted symbol, so a short directed stall keeps the input stream blocked while the held bit is compared cycle by cycle.

// File: rtl/rx_line_pkg.sv
package rx_line_pkg;

  // number of symbols in front of a substitution pulse that get blanked
  localparam int BLANK_SPAN = 3;

  typedef enum logic [1:0] {
    IF_SINGLE = 2'b00,
    IF_DUAL   = 2'b01,
    IF_RAW    = 2'b10,
    IF_RAW_B  = 2'b11
  } if_mode_e;

  // one symbol held in the delay window
  typedef struct packed {
    logic vld;
    logic rda;   // data or positive rail
    logic rdb;   // violation or negative rail
  } slot_t;

endpackage

// File: rtl/rx_sym_judge.sv
module rx_sym_judge
  import rx_line_pkg::*;
(
  input  logic       single_mode,
  input  logic       hdb3_en,
  input  logic       pos,
  input  logic       neg,
  input  logic       have_mark,
  input  logic       last_pos,
  input  logic [1:0] prior_marks,
  output slot_t      sym,
  output logic       is_mark,
  output logic       sub_hit
);

  logic same_pol;
  logic two_spaces;

  always_comb begin
    is_mark    = pos ^ neg;
    same_pol   = is_mark && have_mark && (pos == last_pos);
    two_spaces = !prior_marks[0] && !prior_marks[1];
    sub_hit    = 1'b0;
    sym.vld    = 1'b1;
    if (!single_mode) begin
      sym.rda = pos;
      sym.rdb = neg;
    end else if (!hdb3_en) begin
      sym.rda = is_mark;
      sym.rdb = same_pol;
    end else begin
      sub_hit = same_pol && two_spaces;
      sym.rda = is_mark && !sub_hit;
      sym.rdb = same_pol && !sub_hit;
    end
  end

endmodule

// File: rtl/rx_sym_window.sv
module rx_sym_window
  import rx_line_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  shift,
  input  logic  pop,
  input  logic  blank,
  input  slot_t din,
  output slot_t tail
);

  localparam int LAST = DEPTH - 1;

  slot_t st [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n)     st[0] <= '0;
        else if (shift) st[0] <= din;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          st[i] <= '0;
        end else if (shift) begin
          st[i].vld <= st[i-1].vld;
          st[i].rdb <= st[i-1].rdb;
          st[i].rda <= (blank && (i <= BLANK_SPAN)) ? 1'b0 : st[i-1].rda;
        end else if (pop && (i == LAST)) begin
          st[i].vld <= 1'b0;
        end
      end
    end
  end

  assign tail = st[LAST];

endmodule

// File: rtl/rx_out_format.sv
module rx_out_format
  import rx_line_pkg::*;
(
  input  logic  raw_mode,
  input  logic  edge_hi,
  input  logic  in_valid,
  input  logic  in_pos,
  input  logic  in_neg,
  input  logic  out_ready,
  input  slot_t tail,
  output logic  in_ready,
  output logic  out_valid,
  output logic  out_rda,
  output logic  out_rdb,
  output logic  rclk_o
);

  always_comb begin
    if (raw_mode) begin
      in_ready  = out_ready;
      out_valid = in_valid;
      out_rda   = ~(in_pos ^ edge_hi);
      out_rdb   = ~(in_neg ^ edge_hi);
      rclk_o    = in_pos ^ in_neg;
    end else begin
      in_ready  = !tail.vld || out_ready;
      out_valid = tail.vld;
      out_rda   = tail.rda;
      out_rdb   = tail.rdb;
      rclk_o    = (tail.vld && out_ready) ^ edge_hi;
    end
  end

endmodule

// File: rtl/rx_line_fmt.sv
module rx_line_fmt
  import rx_line_pkg::*;
#(
  parameter int WIN_DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       hdb3_en,
  input  logic       edge_hi,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic       in_pos,
  input  logic       in_neg,
  output logic       out_valid,
  input  logic       out_ready,
  output logic       out_rda,
  output logic       out_rdb,
  output logic       rclk_o
);

  localparam int MIN_DEPTH = BLANK_SPAN + 1;
  localparam int DEPTH_USE = (WIN_DEPTH < MIN_DEPTH) ? MIN_DEPTH : WIN_DEPTH;

  if_mode_e mode_e;
  logic     raw_mode;
  logic     single_mode;
  logic     in_fire;
  logic     shift;
  logic     pop;
  logic     have_mark;
  logic     last_pos;
  logic [1:0] prior_marks;
  slot_t    sym;
  slot_t    tail;
  logic     is_mark;
  logic     sub_hit;

  assign mode_e      = if_mode_e'(mode);
  assign raw_mode    = (mode_e == IF_RAW) || (mode_e == IF_RAW_B);
  assign single_mode = (mode_e == IF_SINGLE);
  assign in_fire     = in_valid && in_ready;
  assign shift       = in_fire && !raw_mode;
  assign pop         = !raw_mode && tail.vld && out_ready;

  // polarity and spacing history of the single-rail stream
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_mark   <= 1'b0;
      last_pos    <= 1'b0;
      prior_marks <= 2'b00;
    end else if (shift && single_mode) begin
      prior_marks <= {prior_marks[0], is_mark};
      if (is_mark) begin
        have_mark <= 1'b1;
        last_pos  <= in_pos;
      end
    end
  end

  rx_sym_judge u_judge (
    .single_mode (single_mode),
    .hdb3_en     (hdb3_en),
    .pos         (in_pos),
    .neg         (in_neg),
    .have_mark   (have_mark),
    .last_pos    (last_pos),
    .prior_marks (prior_marks),
    .sym         (sym),
    .is_mark     (is_mark),
    .sub_hit     (sub_hit)
  );

  rx_sym_window #(.DEPTH(DEPTH_USE)) u_window (
    .clk   (clk),
    .rst_n (rst_n),
    .shift (shift),
    .pop   (pop),
    .blank (sub_hit),
    .din   (sym),
    .tail  (tail)
  );

  rx_out_format u_format (
    .raw_mode  (raw_mode),
    .edge_hi   (edge_hi),
    .in_valid  (in_valid),
    .in_pos    (in_pos),
    .in_neg    (in_neg),
    .out_ready (out_ready),
    .tail      (tail),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_rda   (out_rda),
    .out_rdb   (out_rdb),
    .rclk_o    (rclk_o)
  );

endmodule

// File: rtl/rx_line_fmt_chk.sv
module rx_line_fmt_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       edge_hi,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic       out_rda,
  input logic       out_rdb,
  input logic       rclk_o
);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[1] && out_valid && !out_ready) |=>
      (!$stable(mode) || (out_valid && $stable(out_rda) && $stable(out_rdb))));

  // R10
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[1] && out_valid && !out_ready) |-> !in_ready);

  // R8
  raw_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode[1] |-> (rclk_o == (out_rda ^ out_rdb)));

  // R7
  raw_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode[1] |-> ((out_valid == in_valid) && (in_ready == out_ready)));

  // R3
  flag_on_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && out_valid && out_rdb) |-> out_rda);

  // R9
  idle_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode[1] && !out_valid) |-> (rclk_o == edge_hi));

endmodule

bind rx_line_fmt rx_line_fmt_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode      (mode),
  .edge_hi   (edge_hi),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_rda   (out_rda),
  .out_rdb   (out_rdb),
  .rclk_o    (rclk_o)
);

// File: tb/test_rx_line_fmt.sv
module test_rx_line_fmt;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       hdb3_en = 1'b0;
  logic       edge_hi = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic       in_pos = 1'b0;
  logic       in_neg = 1'b0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic       out_rda;
  logic       out_rdb;
  logic       rclk_o;

  int total = 0;
  int bad = 0;
  logic [63:0] got_a, got_b;
  int ngot = 0;
  logic collect_en = 1'b0;

  always #10 clk = ~clk;

  rx_line_fmt i_rx_line_fmt (
    .clk(clk), .rst_n(rst_n), .mode(mode), .hdb3_en(hdb3_en), .edge_hi(edge_hi),
    .in_valid(in_valid), .in_ready(in_ready), .in_pos(in_pos), .in_neg(in_neg),
    .out_valid(out_valid), .out_ready(out_ready), .out_rda(out_rda),
    .out_rdb(out_rdb), .rclk_o(rclk_o)
  );

  // record every output transfer, sampled mid-cycle
  always begin
    @(negedge clk);
    #5;
    if (collect_en && out_valid && out_ready && ngot < 64) begin
      got_a[ngot] = out_rda;
      got_b[ngot] = out_rdb;
      ngot++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] m, input logic h, input logic e);
    @(negedge clk);
    rst_n = 1'b0; mode = m; hdb3_en = h; edge_hi = e;
    in_valid = 1'b0; in_pos = 1'b0; in_neg = 1'b0; out_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    ngot = 0;
    collect_en = !m[1];
  endtask

  task automatic push(input logic p, input logic n);
    @(negedge clk);
    in_valid = 1'b1; in_pos = p; in_neg = n;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic flush();
    for (int i = 0; i < 3; i++) push(1'b0, 1'b0);
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_seq(input string req, input int n,
                            input logic [15:0] ea, input logic [15:0] eb);
    check({req, " count"}, (ngot >= n) ? 1 : 0, 1);
    for (int i = 0; i < n; i++) begin
      check({req, " data"}, int'(got_a[i]), int'(ea[i]));
      check({req, " flag"}, int'(got_b[i]), int'(eb[i]));
    end
  endtask

  task automatic t_reset();
    do_reset(2'b00, 1'b0, 1'b1);
    #5;
    check("R1 out_valid", int'(out_valid), 0);
    check("R1 in_ready", int'(in_ready), 1);
    check("R1 rclk_o", int'(rclk_o), 1);
  endtask

  task automatic t_ami();
    do_reset(2'b00, 1'b0, 1'b0);
    push(1,0); push(0,0); push(0,1);
    #5; check("R2 latency", int'(out_valid), 0);
    push(1,1); push(1,0); push(0,1);
    flush();
    expect_seq("R2 ami", 6, 16'b110101, 16'b0);
  endtask

  task automatic t_ami_viol();
    do_reset(2'b00, 1'b0, 1'b0);
    push(1,0); push(1,0); push(0,0); push(0,1); push(0,1);
    flush();
    expect_seq("R3 ami violation", 5, 16'b11011, 16'b10010);
  endtask

  task automatic t_hdb3_sub();
    do_reset(2'b00, 1'b1, 1'b0);
    push(1,0); push(0,0); push(0,0); push(0,0); push(1,0);
    push(0,1); push(1,0); push(0,0); push(0,0); push(1,0); push(0,1);
    flush();
    expect_seq("R4 hdb3 substitution", 11, 16'b100_0010_0001, 16'b0);
  endtask

  task automatic t_hdb3_bad();
    do_reset(2'b00, 1'b1, 1'b0);
    push(1,0); push(0,0); push(1,0); push(0,1); push(0,1);
    flush();
    expect_seq("R5 hdb3 bad violation", 5, 16'b11101, 16'b10100);
  endtask

  task automatic t_dual();
    do_reset(2'b01, 1'b0, 1'b0);
    push(1,0); push(0,1); push(1,1); push(0,0);
    flush();
    expect_seq("R6 dual rail", 4, 16'b0101, 16'b0110);
  endtask

  task automatic t_raw();
    do_reset(2'b10, 1'b0, 1'b1);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      edge_hi = k[2]; in_pos = k[0]; in_neg = k[1]; in_valid = 1'b1;
      #1;
      check("R7 raw rda", int'(out_rda), k[2] ? k[0] : !k[0]);
      check("R7 raw rdb", int'(out_rdb), k[2] ? k[1] : !k[1]);
      check("R8 raw clock", int'(rclk_o), k[0] ^ k[1]);
      check("R7 raw valid", int'(out_valid), 1);
    end
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0;
    #1;
    check("R7 raw ready", int'(in_ready), 0);
    check("R7 raw valid low", int'(out_valid), 0);
  endtask

  task automatic t_edge(input logic e);
    do_reset(2'b01, 1'b0, e);
    #5; check("R9 idle clock", int'(rclk_o), int'(e));
    push(1,0); push(0,1); push(1,0); push(0,1);
    check("R9 transfer valid", int'(out_valid), 1);
    check("R9 transfer clock", int'(rclk_o), int'(!e));
    repeat (3) @(negedge clk);
    #5; check("R9 idle after", int'(rclk_o), int'(e));
  endtask

  task automatic t_stall();
    do_reset(2'b01, 1'b0, 1'b0);
    out_ready = 1'b0;
    push(1,0); push(0,1); push(1,1); push(1,0);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); #5;
      check("R10 held valid", int'(out_valid), 1);
      check("R10 held rda", int'(out_rda), 1);
      check("R10 held rdb", int'(out_rdb), 0);
      check("R10 input blocked", int'(in_ready), 0);
    end
    @(negedge clk);
    out_ready = 1'b1;
    push(0,1);
    flush();
    expect_seq("R10 order after stall", 5, 16'b01101, 16'b10110);
  endtask

  initial begin
    #(20 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_ami();
    t_ami_viol();
    t_hdb3_sub();
    t_hdb3_bad();
    t_dual();
    t_raw();
    t_edge(1'b0);
    t_edge(1'b1);
    t_stall();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule